// File: doc/BRIEF.md
# Micro-op Issue Timing Scoreboard

This block sits between a single-issue micro-op stream and a group of execution pipes. It decides cycle by cycle whether the op on offer may start. It then reports that op's completion on one shared writeback port. No arithmetic is done here: the block keeps only timing state and destination tags. Each op names an operation class. Each class has a fixed result latency and a fixed minimum spacing between starts, called the initiation interval. Some classes are fully pipelined, one is half-pipelined and the divider is not pipelined at all.

Per class, the block holds a small gate state machine with two states. `GATE_OPEN` means a new op may start. `GATE_HOLD` means the class is still inside its initiation interval. A start in `GATE_OPEN` with an interval above one moves the gate to `GATE_HOLD` (transition *start*). The gate stays there while a down-counter runs (transition *count*) and goes back to `GATE_OPEN` when the counter reaches zero (transition *expire*). A flush or reset forces `GATE_OPEN` (transition *clear*). A completion slot line, one slot per future cycle, holds the writeback reservations and shifts toward the output every cycle.

Refused ops are not stored. The source must offer them again in a later cycle.

Top module: `issue_sched`

## Requirements
- R1: Class code 0 (integer ALU) has latency 1 and interval 1, so it is never refused for rate reasons.
- R2: Class code 1 (integer load) has latency 3 and interval 1.
- R3: Class code 2 (integer multiply) has latency 4 and interval 1.
- R4: Class code 3 (floating add) has latency 3 and interval 1.
- R5: Class code 4 (floating multiply) has latency 5 and interval 2. An op of this class offered in the cycle right after an accepted one is refused.
- R6: Class code 5 (floating divide) has latency 32 and interval 32. After an accepted divide, further divides are refused for the next 31 cycles.
- R7: Every accepted op (`issue_ack` high) produces exactly one `done_valid` pulse carrying its tag, exactly latency cycles after the acceptance cycle.
- R8: An op whose class is still inside its interval gets `rej_rate`. It is not accepted, it produces no completion, and the same op is accepted once the interval has passed.
- R9: An op that passes the rate check, but whose completion cycle is already held by an earlier op, gets `rej_wb` and produces no completion. When both causes apply, `rej_rate` wins.
- R10: While `flush` is high, no op is accepted and `done_valid` is low. In the cycle after a flush, every pending completion is gone and every class is open.
- R11: Class codes 6 and 7 are reserved. Such an op gets none of `issue_ack`, `rej_rate` or `rej_wb`, and it produces no completion.
- R12: After reset, `done_valid` is low and every class is open.
- R13: With `req_valid` low, `issue_ack`, `rej_rate` and `rej_wb` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Cancel all pending completions and open all classes |
| req_valid | input | 1 | An op is offered this cycle |
| req_class | input | 3 | Operation class code of the offered op |
| req_tag | input | TAG_W | Destination tag of the offered op |
| issue_ack | output | 1 | Offered op is accepted this cycle |
| rej_rate | output | 1 | Refused: class interval not yet over |
| rej_wb | output | 1 | Refused: writeback cycle already reserved |
| done_valid | output | 1 | A result completes this cycle |
| done_tag | output | TAG_W | Tag of the completing result |

## Verification
The accept and refuse outputs are combinational, so they are due in the same cycle as the offer. A completion is due exactly latency cycles later: an op accepted in cycle t shows on `done_valid` in cycle t+L. The bench keeps a cycle-indexed reservation ring and a per-class earliest-start cycle, and fills the ring at slot t+L when an op is accepted. Inputs are driven at the falling edge and every output is compared one time step later, in every cycle, against the ring slot for that cycle. This makes an early, late, missing or duplicated pulse visible in the exact cycle where it differs.

// File: rtl/issue_sched_pkg.sv
package issue_sched_pkg;

    localparam int NUM_CLASS = 6;
    localparam int CLS_W     = 3;

    typedef enum logic [CLS_W-1:0] {
        OP_ALU  = 3'd0,
        OP_LOAD = 3'd1,
        OP_IMUL = 3'd2,
        OP_FADD = 3'd3,
        OP_FMUL = 3'd4,
        OP_FDIV = 3'd5
    } op_class_e;

    typedef enum logic {
        GATE_OPEN = 1'b0,
        GATE_HOLD = 1'b1
    } gate_state_e;

    function automatic int unsigned op_latency(input int unsigned c);
        case (c)
            0:       return 1;
            1:       return 3;
            2:       return 4;
            3:       return 3;
            4:       return 5;
            5:       return 32;
            default: return 0;
        endcase
    endfunction

    function automatic int unsigned op_interval(input int unsigned c);
        case (c)
            4:       return 2;
            5:       return 32;
            default: return 1;
        endcase
    endfunction

    function automatic int unsigned max_latency();
        int unsigned m;
        m = 1;
        for (int c = 0; c < NUM_CLASS; c++) begin
            if (op_latency(c) > m) m = op_latency(c);
        end
        return m;
    endfunction

    localparam int MAX_LAT = max_latency();

endpackage

// File: rtl/issue_rate_gate.sv
module issue_rate_gate
    import issue_sched_pkg::*;
#(
    parameter int II = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic fire,
    output logic ready
);
    localparam int CNT_W  = (II > 2) ? $clog2(II) : 1;
    localparam int HOLD_N = (II > 1) ? II - 2 : 0;

    gate_state_e          state_q, state_d;
    logic [CNT_W-1:0]     cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GATE_OPEN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (flush) begin
            state_d = GATE_OPEN;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                GATE_OPEN: begin
                    if (fire && (II > 1)) begin
                        state_d = GATE_HOLD;
                        cnt_d   = CNT_W'(HOLD_N);
                    end
                end
                GATE_HOLD: begin
                    if (cnt_q == '0) begin
                        state_d = GATE_OPEN;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                default: state_d = GATE_OPEN;
            endcase
        end
    end

    // outputs
    always_comb begin
        ready = (state_q == GATE_OPEN);
    end

endmodule

// File: rtl/issue_wb_slots.sv
module issue_wb_slots #(
    parameter int DEPTH = 32,
    parameter int TAG_W = 6,
    parameter int LAT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [LAT_W-1:0] probe_lat,
    output logic             probe_busy,
    input  logic             wr_en,
    input  logic [TAG_W-1:0] wr_tag,
    output logic             out_v,
    output logic [TAG_W-1:0] out_tag
);
    logic [DEPTH-1:0] slot_v;
    logic [TAG_W-1:0] slot_tag [DEPTH];

    // slot k holds the op that finishes k cycles from now
    always_comb begin
        probe_busy = 1'b0;
        for (int k = 1; k < DEPTH; k++) begin
            if (probe_lat == LAT_W'(k)) probe_busy = slot_v[k];
        end
    end

    for (genvar k = 0; k < DEPTH; k++) begin : g_slot
        logic             nxt_v;
        logic [TAG_W-1:0] nxt_tag;
        if (k == DEPTH - 1) begin : g_top
            assign nxt_v   = 1'b0;
            assign nxt_tag = '0;
        end else begin : g_mid
            assign nxt_v   = slot_v[k+1];
            assign nxt_tag = slot_tag[k+1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_v[k]   <= 1'b0;
                slot_tag[k] <= '0;
            end else if (flush) begin
                slot_v[k]   <= 1'b0;
            end else if (wr_en && (probe_lat == LAT_W'(k + 1))) begin
                slot_v[k]   <= 1'b1;
                slot_tag[k] <= wr_tag;
            end else begin
                slot_v[k]   <= nxt_v;
                slot_tag[k] <= nxt_tag;
            end
        end
    end

    assign out_v   = slot_v[0];
    assign out_tag = slot_tag[0];

endmodule

// File: rtl/issue_sched.sv
module issue_sched
    import issue_sched_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             req_valid,
    input  logic [2:0]       req_class,
    input  logic [TAG_W-1:0] req_tag,
    output logic             issue_ack,
    output logic             rej_rate,
    output logic             rej_wb,
    output logic             done_valid,
    output logic [TAG_W-1:0] done_tag
);
    localparam int DEPTH = MAX_LAT;
    localparam int LAT_W = $clog2(DEPTH + 1);

    logic [NUM_CLASS-1:0] gate_ready;
    logic [NUM_CLASS-1:0] gate_fire;
    logic                 cls_ok;
    logic                 rate_ok;
    logic [LAT_W-1:0]     lat_sel;
    logic                 wb_busy;
    logic                 slot_v;

    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_gate
        assign gate_fire[c] = issue_ack && (req_class == CLS_W'(c));
        issue_rate_gate #(.II(op_interval(c))) u_gate (
            .clk   (clk),
            .rst_n (rst_n),
            .flush (flush),
            .fire  (gate_fire[c]),
            .ready (gate_ready[c])
        );
    end

    always_comb begin
        cls_ok  = (int'(req_class) < NUM_CLASS);
        rate_ok = 1'b0;
        for (int c = 0; c < NUM_CLASS; c++) begin
            if (req_class == CLS_W'(c)) rate_ok = gate_ready[c];
        end
        lat_sel = cls_ok ? LAT_W'(op_latency(int'(req_class))) : '0;
    end

    // issue decision: rate refusal takes priority over writeback refusal
    always_comb begin
        issue_ack = 1'b0;
        rej_rate  = 1'b0;
        rej_wb    = 1'b0;
        if (req_valid && !flush && cls_ok) begin
            if (!rate_ok)     rej_rate  = 1'b1;
            else if (wb_busy) rej_wb    = 1'b1;
            else              issue_ack = 1'b1;
        end
    end

    issue_wb_slots #(.DEPTH(DEPTH), .TAG_W(TAG_W), .LAT_W(LAT_W)) u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .probe_lat  (lat_sel),
        .probe_busy (wb_busy),
        .wr_en      (issue_ack),
        .wr_tag     (req_tag),
        .out_v      (slot_v),
        .out_tag    (done_tag)
    );

    assign done_valid = slot_v && !flush;

endmodule

// File: rtl/issue_sched_chk.sv
module issue_sched_chk
    import issue_sched_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             req_valid,
    input logic [2:0]       req_class,
    input logic [TAG_W-1:0] req_tag,
    input logic             issue_ack,
    input logic             rej_rate,
    input logic             rej_wb,
    input logic             done_valid,
    input logic [TAG_W-1:0] done_tag
);
    a_r9_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({issue_ack, rej_rate, rej_wb}));

    a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !(issue_ack || rej_rate || rej_wb));

    a_r10_flush_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!issue_ack && !done_valid));

    a_r10_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !done_valid);

    a_r1_alu_never_rate: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_class == 3'(OP_ALU)) |-> !rej_rate);

    a_r7_alu_next: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_ack && req_class == 3'(OP_ALU)) |=>
            (flush || (done_valid && done_tag == $past(req_tag))));

    a_r5_fmul_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_ack && req_class == 3'(OP_FMUL)) |=>
            !(issue_ack && req_class == 3'(OP_FMUL)));

    a_r11_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (req_class[2:1] == 2'b11) |-> !(issue_ack || rej_rate || rej_wb));

endmodule

bind issue_sched issue_sched_chk #(.TAG_W(TAG_W)) u_chk (.*);

// File: tb/issue_sched_tb.sv
module issue_sched_tb;
    localparam int TAG_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             flush = 1'b0;
    logic             req_valid = 1'b0;
    logic [2:0]       req_class = '0;
    logic [TAG_W-1:0] req_tag = '0;
    logic             issue_ack, rej_rate, rej_wb, done_valid;
    logic [TAG_W-1:0] done_tag;

    always #4 clk = ~clk;

    issue_sched #(.TAG_W(TAG_W)) u_dut (.*);

    int nchk = 0;
    int nerr = 0;
    bit ended = 0;

    // bench reference: completions by absolute cycle, earliest start per class
    bit               ring_v [64];
    logic [TAG_W-1:0] ring_t [64];
    int               ring_c [64];
    longint           free_at [6];
    longint           now = 0;

    function automatic int lat_of(input int c);
        case (c)
            0: return 1;  1: return 3;  2: return 4;
            3: return 3;  4: return 5;  default: return 32;
        endcase
    endfunction

    function automatic int ii_of(input int c);
        return (c == 4) ? 2 : (c == 5) ? 32 : 1;
    endfunction

    function automatic string req_of(input int c);
        case (c)
            0: return "R1"; 1: return "R2"; 2: return "R3";
            3: return "R4"; 4: return "R5"; default: return "R6";
        endcase
    endfunction

    task automatic chk(input string rq, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", rq, what, act, exp, now);
        end
    endtask

    task automatic finish_up();
        if (!ended) begin
            ended = 1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    endtask

    // one cycle: drive at falling edge, check, update reference
    task automatic step(input bit v, input int c, input int t, input bit f);
        int  idx, tgt;
        bit  e_ack, e_rr, e_rw, e_dv;
        string rq, dq;
        req_valid = v;
        req_class = 3'(c);
        req_tag   = TAG_W'(t);
        flush     = f;
        #1;
        idx = int'(now % 64);
        e_ack = 0; e_rr = 0; e_rw = 0;
        tgt = 0;
        if (!v)          rq = "R13";
        else if (f)      rq = "R10";
        else if (c > 5)  rq = "R11";
        else begin
            tgt = int'((now + lat_of(c)) % 64);
            if (now < free_at[c])  begin e_rr = 1;  rq = "R8"; end
            else if (ring_v[tgt])  begin e_rw = 1;  rq = "R9"; end
            else                   begin e_ack = 1; rq = req_of(c); end
        end
        chk(rq, "issue_ack", int'(issue_ack), int'(e_ack));
        chk(rq, "rej_rate",  int'(rej_rate),  int'(e_rr));
        chk(rq, "rej_wb",    int'(rej_wb),    int'(e_rw));
        e_dv = ring_v[idx] && !f;
        dq = f ? "R10" : ring_v[idx] ? req_of(ring_c[idx]) : "R7";
        chk(dq, "done_valid", int'(done_valid), int'(e_dv));
        if (e_dv && done_valid) chk("R7", "done_tag", int'(done_tag), int'(ring_t[idx]));
        ring_v[idx] = 0;
        if (f) begin
            for (int k = 0; k < 64; k++) ring_v[k] = 0;
            for (int k = 0; k < 6; k++)  free_at[k] = 0;
        end else if (e_ack) begin
            ring_v[tgt] = 1;
            ring_t[tgt] = TAG_W'(t);
            ring_c[tgt] = c;
            free_at[c]  = now + ii_of(c);
        end
        now++;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        logic [15:0] lfsr;
        for (int k = 0; k < 64; k++) begin ring_v[k] = 0; ring_t[k] = '0; ring_c[k] = 0; end
        for (int k = 0; k < 6; k++) free_at[k] = 0;

        // R12: reset state
        repeat (3) @(negedge clk);
        chk("R12", "done_valid in reset", int'(done_valid), 0);
        chk("R12", "issue_ack in reset idle", int'(issue_ack), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12", "done_valid after reset", int'(done_valid), 0);
        // every class open right after reset (R12)
        for (int c = 0; c < 6; c++) begin
            step(1, c, 10 + c, 0);
            idle(34);
        end

        // back-to-back streams per class: R1..R6, R8
        for (int c = 0; c < 6; c++) begin
            for (int i = 0; i < 5; i++) step(1, c, c * 8 + i, 0);
            idle(34);
        end

        // refused divide offered again until accepted (R8, R6)
        step(1, 5, 1, 0);
        for (int i = 0; i < 32; i++) step(1, 5, 2, 0);
        idle(34);

        // pair sweep over classes and gaps: R7, R8, R9
        for (int a = 0; a < 6; a++)
            for (int b = 0; b < 6; b++)
                for (int g = 1; g <= 6; g++) begin
                    step(0, 0, 0, 1);
                    step(1, a, 21, 0);
                    idle(g - 1);
                    step(1, b, 42, 0);
                    idle(33);
                end

        // flush with ops in flight (R10)
        step(1, 5, 5, 0);
        step(1, 1, 6, 0);
        step(1, 4, 7, 0);
        idle(1);
        step(1, 0, 8, 1);
        step(1, 5, 9, 0);
        step(1, 4, 11, 0);
        idle(34);

        // reserved codes (R11)
        for (int c = 6; c < 8; c++) begin
            step(1, c, 3, 0);
            idle(34);
        end

        // pseudo-random mixed stream
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[5], int'(lfsr[3:1]), int'(lfsr[11:6]), (lfsr[15:10] == 6'd0));
        end
        idle(40);

        finish_up();
    end
endmodule